// File: doc/BRIEF.md
# DRAM Row-Strobe Bank Decoder with Page Tracking

This block turns a physical CPU byte address into a choice of one row-strobe line among eight DRAM banks. The banks form four blocks. Block k holds bank k and bank k+4. Each bank has three settings: a base address, a 3-bit depth code that sets its size, and an interleave enable. The decoder checks the request address against the window of every enabled bank. It applies even/odd page interleaving where a setting calls for it, and picks one winner.

On top of the decode sits a small page tracker. It remembers which bank and which DRAM page are open. Each accepted request is classified as a page hit, a page miss or an unmapped access, and the row strobes are driven so that at most one is ever active. A miss that replaces an open page always passes through one cycle with every strobe released. Timing sequencing, refresh and row/column multiplexing sit outside this block.

Top module: `dram_bank_decoder`

## Requirements
- R1: Depth code sets the bank window for a 32-bit-wide bank. Code 1 gives 1 MB, code 2 gives 4 MB, code 3 gives 16 MB and code 4 gives 64 MB. Codes 0 and 5 to 7 disable the bank.
- R2: Base-address bits below the window size are ignored. A 16 MB bank with base 0x0130_0000 decodes 0x0100_0000 to 0x01FF_FFFF.
- R3: A bank whose block partner is disabled and whose interleave bit is 1 gets a window of twice its size. It answers only on pages whose parity (address bit COL_W) equals its own bank-number parity: even banks take even pages, odd banks take odd pages.
- R4: When both banks of a block are enabled, both are interleaved whatever their interleave bits. The lower bank k takes even pages and the upper bank k+4 takes odd pages, each over twice its own size.
- R5: If several enabled banks match, the lowest-numbered one is chosen and overlap_o pulses together with the result.
- R6: An address that no enabled bank matches pulses unmapped_o, releases all strobes and closes any open page.
- R7: A request to the open bank with the same page number (address bits above COL_W) pulses hit_o and keeps the strobe asserted without a break.
- R8: A request that misses while a page is open pulses miss_o. The next cycle shows all strobes released, and the cycle after that asserts the new bank's strobe.
- R9: A request that maps while no page is open pulses miss_o, and the new strobe is asserted in the same cycle as that pulse.
- R10: At most one bit of row_sel_o is set in any cycle.
- R11: A request presented during the released-strobe cycle of R8 is dropped. It yields no result pulse and does not change the strobe that follows.
- R12: Synchronous reset releases all strobes, clears the result pulses and forgets the open page, so the next mapped request is a miss.
- R13: Exactly one of hit_o, miss_o and unmapped_o pulses, for one cycle, in the cycle after the clock edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Access request, one cycle per access |
| addr_i | input | ADDR_W | Physical byte address of the access |
| bank_start_i | input | NUM_BANKS*ADDR_W | Base address of each bank, bank i at bits [i*ADDR_W +: ADDR_W] |
| bank_depth_i | input | NUM_BANKS*3 | Depth code of each bank, bank i at bits [i*3 +: 3] |
| bank_ilv_i | input | NUM_BANKS | Interleave enable of each bank |
| row_sel_o | output | NUM_BANKS | Active-high row strobes, bit i for bank i |
| hit_o | output | 1 | Page-hit pulse |
| miss_o | output | 1 | Page-miss pulse |
| unmapped_o | output | 1 | No-bank-matched pulse |
| overlap_o | output | 1 | Several banks matched the request |

## Verification
The result pulses are registered once. They are due in the cycle after the edge that samples req_i, and they must be clear again one cycle later. The strobe follows one of two paths. After a hit, or a miss from the idle state, it takes its final value in that same cycle. After a miss from an open page it first reads zero and reaches its final value one cycle later. The bench drives every request on a falling edge, samples the pulses and the intermediate strobe on the next falling edge, and samples the settled strobe and the cleared pulses on the falling edge after that. The gap-cycle test places its second request exactly on the released-strobe cycle.

// File: rtl/ddec_pkg.sv
package ddec_pkg;

    // log2 of the bytes behind depth code 1 divided by 4 (1 MB bank of 32-bit words)
    localparam int WIN_LOG2_BASE = 18;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_GAP  = 2'd2
    } page_state_t;

    function automatic logic code_ok(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd4);
    endfunction

    // each depth step multiplies the device depth by four; interleave doubles
    function automatic int win_log2(input logic [2:0] code, input logic ilv);
        return WIN_LOG2_BASE + 2 * int'(code) + int'(ilv);
    endfunction

endpackage

// File: rtl/ddec_bank_match.sv
module ddec_bank_match
    import ddec_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int COL_W     = 11,
    parameter int NUM_BANKS = 8,
    parameter int BANK_IDX  = 0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [2:0]        depth_i,
    input  logic [2:0]        partner_depth_i,
    input  logic              ilv_i,
    output logic              match_o
);

    localparam bit UPPER_HALF = (BANK_IDX >= NUM_BANKS / 2);
    localparam bit ODD_INDEX  = (BANK_IDX % 2) == 1;

    logic              paired;
    logic              ilv_eff;
    logic              want_odd;
    logic [ADDR_W-1:0] win_mask;
    logic              in_window;
    logic              parity_ok;
    int                lg;

    always_comb begin
        paired    = code_ok(depth_i) && code_ok(partner_depth_i);
        ilv_eff   = paired || ilv_i;
        want_odd  = paired ? UPPER_HALF : ODD_INDEX;
        lg        = win_log2(depth_i, ilv_eff);
        win_mask  = ~((ADDR_W'(1) << lg) - ADDR_W'(1));
        in_window = ((addr_i ^ start_i) & win_mask) == '0;
        parity_ok = !ilv_eff || (addr_i[COL_W] == want_odd);
        match_o   = code_ok(depth_i) && in_window && parity_ok;
    end

endmodule

// File: rtl/ddec_prio.sv
module ddec_prio #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 3
) (
    input  logic [NUM_BANKS-1:0] match_i,
    output logic                 valid_o,
    output logic [BANK_W-1:0]    bank_o,
    output logic                 multi_o
);

    always_comb begin
        bank_o = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (match_i[i]) bank_o = BANK_W'(i);
        end
        valid_o = |match_i;
        multi_o = $countones(match_i) > 1;
    end

endmodule

// File: rtl/ddec_page_fsm.sv
module ddec_page_fsm
    import ddec_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 3,
    parameter int PAGE_W    = 21
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_i,
    input  logic                 dec_valid_i,
    input  logic [BANK_W-1:0]    dec_bank_i,
    input  logic [PAGE_W-1:0]    dec_page_i,
    input  logic                 dec_multi_i,
    output logic [NUM_BANKS-1:0] row_sel_o,
    output logic                 hit_o,
    output logic                 miss_o,
    output logic                 unmapped_o,
    output logic                 overlap_o
);

    page_state_t       state, state_nxt;
    logic [BANK_W-1:0] open_bank;
    logic [PAGE_W-1:0] open_page;
    logic              accept;
    logic              same_page;

    assign accept    = req_i && (state != ST_GAP);
    assign same_page = (open_bank == dec_bank_i) && (open_page == dec_page_i);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (req_i) state_nxt = dec_valid_i ? ST_OPEN : ST_IDLE;
            ST_OPEN: if (req_i) begin
                if (!dec_valid_i)   state_nxt = ST_IDLE;
                else if (same_page) state_nxt = ST_OPEN;
                else                state_nxt = ST_GAP;
            end
            ST_GAP:  state_nxt = ST_OPEN;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o      <= 1'b0;
            miss_o     <= 1'b0;
            unmapped_o <= 1'b0;
            overlap_o  <= 1'b0;
            open_bank  <= '0;
            open_page  <= '0;
        end else begin
            hit_o      <= accept && dec_valid_i && (state == ST_OPEN) && same_page;
            miss_o     <= accept && dec_valid_i && !((state == ST_OPEN) && same_page);
            unmapped_o <= accept && !dec_valid_i;
            overlap_o  <= accept && dec_valid_i && dec_multi_i;
            if (accept && dec_valid_i) begin
                open_bank <= dec_bank_i;
                open_page <= dec_page_i;
            end
        end
    end

    always_comb begin
        row_sel_o = '0;
        if (state == ST_OPEN) row_sel_o = NUM_BANKS'(1) << open_bank;
    end

endmodule

// File: rtl/dram_bank_decoder.sv
module dram_bank_decoder
    import ddec_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int COL_W     = 11,
    parameter int NUM_BANKS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [NUM_BANKS*ADDR_W-1:0] bank_start_i,
    input  logic [NUM_BANKS*3-1:0]      bank_depth_i,
    input  logic [NUM_BANKS-1:0]        bank_ilv_i,
    output logic [NUM_BANKS-1:0]        row_sel_o,
    output logic                        hit_o,
    output logic                        miss_o,
    output logic                        unmapped_o,
    output logic                        overlap_o
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int PAGE_W = ADDR_W - COL_W;
    localparam int HALF   = NUM_BANKS / 2;

    logic [NUM_BANKS-1:0] match;
    logic                 dec_valid;
    logic [BANK_W-1:0]    dec_bank;
    logic                 dec_multi;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int PARTNER = (g + HALF) % NUM_BANKS;
        ddec_bank_match #(
            .ADDR_W   (ADDR_W),
            .COL_W    (COL_W),
            .NUM_BANKS(NUM_BANKS),
            .BANK_IDX (g)
        ) u_match (
            .addr_i         (addr_i),
            .start_i        (bank_start_i[g*ADDR_W +: ADDR_W]),
            .depth_i        (bank_depth_i[g*3 +: 3]),
            .partner_depth_i(bank_depth_i[PARTNER*3 +: 3]),
            .ilv_i          (bank_ilv_i[g]),
            .match_o        (match[g])
        );
    end

    ddec_prio #(
        .NUM_BANKS(NUM_BANKS),
        .BANK_W   (BANK_W)
    ) u_prio (
        .match_i(match),
        .valid_o(dec_valid),
        .bank_o (dec_bank),
        .multi_o(dec_multi)
    );

    ddec_page_fsm #(
        .NUM_BANKS(NUM_BANKS),
        .BANK_W   (BANK_W),
        .PAGE_W   (PAGE_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_i),
        .dec_valid_i(dec_valid),
        .dec_bank_i (dec_bank),
        .dec_page_i (addr_i[ADDR_W-1:COL_W]),
        .dec_multi_i(dec_multi),
        .row_sel_o  (row_sel_o),
        .hit_o      (hit_o),
        .miss_o     (miss_o),
        .unmapped_o (unmapped_o),
        .overlap_o  (overlap_o)
    );

endmodule

// File: rtl/ddec_checker.sv
module ddec_checker #(
    parameter int NUM_BANKS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_BANKS-1:0] row_sel_o,
    input logic                 hit_o,
    input logic                 miss_o,
    input logic                 unmapped_o,
    input logic                 overlap_o
);

    // R10
    onehot_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel_o));

    // R13
    single_result_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_o, miss_o, unmapped_o}));

    // R7
    hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (row_sel_o != '0) && (row_sel_o == $past(row_sel_o)));

    // R8
    miss_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_o && ($past(row_sel_o) != '0)) |-> (row_sel_o == '0));

    // R8
    gap_reopen_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_o && ($past(row_sel_o) != '0)) |=> (row_sel_o != '0));

    // R9
    idle_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_o && ($past(row_sel_o) == '0)) |-> (row_sel_o != '0));

    // R6
    unmapped_dark_chk: assert property (@(posedge clk) disable iff (rst)
        unmapped_o |-> (row_sel_o == '0));

    // R5
    overlap_result_chk: assert property (@(posedge clk) disable iff (rst)
        overlap_o |-> (hit_o || miss_o));

endmodule

bind dram_bank_decoder ddec_checker #(.NUM_BANKS(NUM_BANKS)) u_ddec_chk (
    .clk       (clk),
    .rst       (rst),
    .row_sel_o (row_sel_o),
    .hit_o     (hit_o),
    .miss_o    (miss_o),
    .unmapped_o(unmapped_o),
    .overlap_o (overlap_o)
);

// File: tb/dram_bank_decoder_bench.sv
`timescale 1ns/1ps
module dram_bank_decoder_bench;

    localparam int NB = 8;
    localparam int AW = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [NB*AW-1:0] bstart = '0;
    logic [NB*3-1:0]  bdepth = '0;
    logic [NB-1:0]    bilv = '0;
    logic [NB-1:0]  row_sel;
    logic           hit, miss, unm, ovl;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dram_bank_decoder #(.ADDR_W(AW), .COL_W(11), .NUM_BANKS(NB)) u_dram_bank_decoder (
        .clk(clk), .rst(rst), .req_i(req), .addr_i(addr),
        .bank_start_i(bstart), .bank_depth_i(bdepth), .bank_ilv_i(bilv),
        .row_sel_o(row_sel), .hit_o(hit), .miss_o(miss),
        .unmapped_o(unm), .overlap_o(ovl)
    );

    // {addr, hit, miss, unmapped, overlap, gap, final strobe}
    localparam logic [44:0] VEC [15] = '{
        {32'h0000_0100, 5'b01000, 8'h01},  // idle miss, bank 0 even page
        {32'h0000_0104, 5'b10000, 8'h01},  // hit
        {32'h0000_0900, 5'b01001, 8'h10},  // odd page, bank 4 (pair)
        {32'h0000_0A00, 5'b10000, 8'h10},  // hit
        {32'h0000_1000, 5'b01001, 8'h01},  // even page back to bank 0
        {32'h0080_0800, 5'b01001, 8'h02},  // bank 1 odd (single interleave)
        {32'h0080_0000, 5'b01001, 8'h04},  // bank 2 even
        {32'h0080_07FC, 5'b10000, 8'h04},  // hit, last word of page
        {32'h0130_0000, 5'b01001, 8'h08},  // bank 3, aligned base
        {32'h0100_0010, 5'b01001, 8'h08},  // same bank other row
        {32'h0100_0020, 5'b10000, 8'h08},  // hit
        {32'h00A0_0000, 5'b00100, 8'h00},  // unmapped
        {32'h00A0_0000, 5'b00100, 8'h00},  // unmapped again
        {32'h0000_0800, 5'b01000, 8'h10},  // idle miss, bank 4
        {32'h0200_0000, 5'b00100, 8'h00}   // unmapped past bank 3
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_bank(input int i, input logic [31:0] s, input logic [2:0] d, input logic il);
        bstart[i*AW +: AW] = s;
        bdepth[i*3 +: 3]   = d;
        bilv[i]            = il;
    endtask

    task automatic cfg_default();
        for (int i = 0; i < NB; i++) set_bank(i, 32'h0, 3'd0, 1'b0);
        set_bank(0, 32'h0000_0000, 3'd2, 1'b1);  // R4: bit set, pairing rules
        set_bank(4, 32'h0000_0000, 3'd2, 1'b1);
        set_bank(1, 32'h0080_0000, 3'd1, 1'b1);
        set_bank(2, 32'h0080_0000, 3'd1, 1'b1);
        set_bank(3, 32'h0130_0000, 3'd3, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_req(input logic [31:0] a, input logic [4:0] ex, input logic [7:0] es, input string tag);
        @(negedge clk);
        req  = 1'b1;
        addr = a;
        @(negedge clk);
        req = 1'b0;
        chk({hit, miss, unm, ovl} == ex[4:1], {tag, " pulses"}, {28'h0, hit, miss, unm, ovl}, {28'h0, ex[4:1]});
        chk(row_sel == (ex[0] ? 8'h00 : es), {tag, " strobe first cycle"}, row_sel, ex[0] ? 8'h00 : es);
        chk($countones(row_sel) <= 1, "R10 single strobe", row_sel, 0);
        @(negedge clk);
        chk({hit, miss, unm, ovl} == 4'b0, "R13 pulses last one cycle", {28'h0, hit, miss, unm, ovl}, 0);
        chk(row_sel == es, {tag, " strobe settled"}, row_sel, es);
        chk($countones(row_sel) <= 1, "R10 single strobe", row_sel, 0);
    endtask

    function automatic string vec_tag(input logic [4:0] ex);
        if (ex[2])      return "R6 unmapped";
        else if (ex[4]) return "R7 hit";
        else if (ex[0]) return "R8 miss with gap";
        else            return "R9 miss from idle";
    endfunction

    initial begin
        #(20 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cfg_default();
        do_reset();
        // R12 reset state
        chk(row_sel == 8'h00, "R12 reset strobes", row_sel, 0);
        chk({hit, miss, unm, ovl} == 4'b0, "R12 reset pulses", {28'h0, hit, miss, unm, ovl}, 0);

        // R1 R2 R3 R4 through the address map
        for (int v = 0; v < 15; v++) begin
            run_req(VEC[v][44:13], VEC[v][12:8], VEC[v][7:0], vec_tag(VEC[v][12:8]));
        end

        // R5 overlap: bank 1 without interleave covers all pages of 0x80_0000..0x8F_FFFF
        do_reset();
        set_bank(1, 32'h0080_0000, 3'd1, 1'b0);
        run_req(32'h0080_0000, 5'b01010, 8'h02, "R5 lowest bank wins");
        run_req(32'h0090_0000, 5'b01001, 8'h04, "R3 window doubled");
        cfg_default();

        // R1 disabled code and 64 MB code
        do_reset();
        set_bank(3, 32'h0130_0000, 3'd5, 1'b0);
        run_req(32'h0100_0000, 5'b00100, 8'h00, "R1 code 5 disabled");
        set_bank(3, 32'h0130_0000, 3'd4, 1'b0);
        run_req(32'h0300_0000, 5'b01000, 8'h08, "R1 64MB window");
        run_req(32'h0400_0000, 5'b00100, 8'h00, "R1 64MB window end");
        cfg_default();

        // R11 request during the gap cycle is dropped
        do_reset();
        run_req(32'h0000_0100, 5'b01000, 8'h01, "R11 setup");
        @(negedge clk);
        req  = 1'b1;
        addr = 32'h0000_0900;
        @(negedge clk);
        addr = 32'h0080_0000;
        chk(miss && row_sel == 8'h00, "R11 gap cycle", {23'h0, miss, row_sel}, {23'h1, 8'h00});
        @(negedge clk);
        req = 1'b0;
        chk({hit, miss, unm, ovl} == 4'b0, "R11 no result for dropped request", {28'h0, hit, miss, unm, ovl}, 0);
        chk(row_sel == 8'h10, "R11 strobe unaffected", row_sel, 8'h10);
        @(negedge clk);
        chk(row_sel == 8'h10, "R11 strobe held", row_sel, 8'h10);

        // R12 reset with a page open
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(row_sel == 8'h00, "R12 reset closes page", row_sel, 0);
        rst = 1'b0;
        run_req(32'h0000_0900, 5'b01000, 8'h10, "R12 page forgotten");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule